// File: doc/BRIEF.md
# Segmented Block-Read Responder

This block sits on the host side of a narrow mailbox between a host and a guest. The guest reads versioned data blocks one byte at a time. Each request names a size class, a block type inside that class and a byte index. A request can instead ask for a checksum over the whole block. The responder decodes the request and reads the block store over a combinational port. It checks the request against the block's recorded length and returns a response message. The response holds a two-bit kind (data, checksum or error) and an eight-bit value.

Every block starts with a two-byte header: byte 0 is the version and byte 1 is the payload length. The message covers the header plus the payload. Types from the three classes form one type space. Small blocks use types 0 to 15 and are 32 bytes long. Medium blocks use types 16 to 23 and are 64 bytes long. Large blocks use types 24 to 27 and are 128 bytes long. The responder serves one request at a time. The mailbox transport and the block contents belong to the surrounding logic.

Top module: `blkrsp_top`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low and `rsp_msg_type` is zero.
- R2: Only request message types 0x09 (small), 0x08 (medium) and 0x07 (large) are accepted. A request with any other type is ignored: `busy` stays low and no response follows.
- R3: Small request: bits 3:0 of `req_data` give the block type (0..15) and bits 8:4 give the byte index.
- R4: Medium request: bits 2:0 plus 16 give the block type (16..23) and bits 8:3 give the byte index.
- R5: Large request: bits 1:0 plus 24 give the block type (24..27) and bits 8:2 give the byte index.
- R6: A response is a one-cycle `rsp_valid` pulse with `rsp_msg_type` equal to 0x03. In `rsp_data`, bits 1:0 are the kind (0 data, 1 checksum, 2 error) and bits 9:2 are the value. A valid byte read returns kind 0 with the stored byte.
- R7: If the store has no block for the decoded type, the response is kind 2 with code 0. This check comes before every other check.
- R8: If the header's message size (2 plus byte 1) exceeds the class length (32, 64 or 128), the response is kind 2 with code 2. This check comes before the index check and before the checksum.
- R9: For a byte read, an index at or beyond 2 plus the payload length gives kind 2 with code 1.
- R10: With request bit 9 set, the response is kind 1 carrying a CRC-8 over bytes 0 through size-1. The CRC uses polynomial 0x97, initial value 0, MSB first, with no reflection or final XOR. It is computed one byte per cycle.
- R11: `busy` rises the cycle after a request is accepted and falls when the response is valid. While `busy` is high, new requests are ignored and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_msg_type | input | 8 | Request message type |
| req_data | input | 10 | Request fields |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_msg_type | output | 8 | Response message type (0x03 when valid) |
| rsp_data | output | 10 | Response kind and value |
| st_type | output | 5 | Block type being read from the store |
| st_byte | output | 7 | Byte index being read from the store |
| st_hit | input | 1 | The store holds a block of type `st_type` |
| st_rdata | input | 8 | Byte `st_byte` of block `st_type` |

## Verification
The hardest case to reach from the ports is a request that satisfies several error conditions at once. One example is a block that is absent and also has an out-of-range index. Another is a truncated header combined with a checksum request. These cases exercise the priority order. The bench builds a store with absent types, with types whose recorded length overflows their class, and with types filled exactly to the class length. Directed reads hit index size-1 and index size. Random requests over freshly randomised stores then mix the error conditions. A second request is also driven in the cycle right after acceptance, to show it is ignored while a long checksum is still running.

// File: rtl/blkrsp_pkg.sv
package blkrsp_pkg;
  localparam int TYPE_W = 5;
  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;
  localparam int MSG_W  = 10;
  localparam int LIM_W  = 8;
  localparam int SIZE_W = BYTE_W + 1;

  localparam logic [7:0] MT_LARGE  = 8'h07;
  localparam logic [7:0] MT_MEDIUM = 8'h08;
  localparam logic [7:0] MT_SMALL  = 8'h09;
  localparam logic [7:0] MT_RESP   = 8'h03;

  localparam int SMALL_TW = 4;
  localparam int MED_TW   = 3;
  localparam int LARGE_TW = 2;
  localparam logic [TYPE_W-1:0] MED_BASE   = TYPE_W'(1 << SMALL_TW);
  localparam logic [TYPE_W-1:0] LARGE_BASE = MED_BASE + TYPE_W'(1 << MED_TW);
  localparam logic [LIM_W-1:0]  SMALL_LEN  = LIM_W'(32);
  localparam logic [LIM_W-1:0]  MED_LEN    = LIM_W'(64);
  localparam logic [LIM_W-1:0]  LARGE_LEN  = LIM_W'(128);
  localparam int CRC_FLAG_BIT = 9;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CRC  = 2'd1,
    KIND_ERR  = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ERR_BAD_TYPE  = 2'd0,
    ERR_BAD_INDEX = 2'd1,
    ERR_TRUNC     = 2'd2,
    ERR_OTHER     = 2'd3
  } err_code_e;

  typedef struct packed {
    logic [TYPE_W-1:0] btype;
    logic [IDX_W-1:0]  index;
    logic              want_crc;
    logic [LIM_W-1:0]  limit;
  } req_fields_t;
endpackage

// File: rtl/blkrsp_decode.sv
module blkrsp_decode
  import blkrsp_pkg::*;
(
  input  logic [7:0]       msg_type,
  input  logic [MSG_W-1:0] msg_data,
  output logic             known,
  output req_fields_t      fields
);
  always_comb begin
    known           = 1'b1;
    fields.want_crc = msg_data[CRC_FLAG_BIT];
    fields.btype    = '0;
    fields.index    = '0;
    fields.limit    = SMALL_LEN;
    case (msg_type)
      MT_SMALL: begin
        fields.btype = TYPE_W'(msg_data[SMALL_TW-1:0]);
        fields.index = IDX_W'(msg_data[8:SMALL_TW]);
        fields.limit = SMALL_LEN;
      end
      MT_MEDIUM: begin
        fields.btype = MED_BASE + TYPE_W'(msg_data[MED_TW-1:0]);
        fields.index = IDX_W'(msg_data[8:MED_TW]);
        fields.limit = MED_LEN;
      end
      MT_LARGE: begin
        fields.btype = LARGE_BASE + TYPE_W'(msg_data[LARGE_TW-1:0]);
        fields.index = IDX_W'(msg_data[8:LARGE_TW]);
        fields.limit = LARGE_LEN;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/blkrsp_crc8.sv
module blkrsp_crc8 #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h97
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc_next
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;

  always_comb begin
    logic [W-1:0] acc;
    acc = crc_q ^ din;
    for (int b = 0; b < W; b++) begin
      acc = acc[W-1] ? ((acc << 1) ^ POLY) : (acc << 1);
    end
    crc_next = acc;
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/blkrsp_top.sv
module blkrsp_top
  import blkrsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_msg_type,
  input  logic [MSG_W-1:0]  req_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [7:0]        rsp_msg_type,
  output logic [MSG_W-1:0]  rsp_data,
  output logic [TYPE_W-1:0] st_type,
  output logic [IDX_W-1:0]  st_byte,
  input  logic              st_hit,
  input  logic [BYTE_W-1:0] st_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_FETCH, S_CRC} state_e;

  state_e             state_q, state_d;
  req_fields_t        req_q, req_d, dec_fields;
  logic               dec_known;
  logic [SIZE_W-1:0]  size_q, size_d, hdr_size;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic               rv_q, rv_d;
  logic [MSG_W-1:0]   rd_q, rd_d;
  logic               accept, crc_clr, crc_en;
  logic [BYTE_W-1:0]  crc_val;

  blkrsp_decode u_dec (
    .msg_type (req_msg_type),
    .msg_data (req_data),
    .known    (dec_known),
    .fields   (dec_fields)
  );

  blkrsp_crc8 #(.W(BYTE_W), .POLY(8'h97)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (crc_clr),
    .en       (crc_en),
    .din      (st_rdata),
    .crc_next (crc_val)
  );

  assign accept   = (state_q == S_IDLE) && req_valid && dec_known;
  assign hdr_size = SIZE_W'(st_rdata) + SIZE_W'(2);
  assign st_type  = req_q.btype;
  assign st_byte  = (state_q == S_HDR)   ? IDX_W'(1) :
                    (state_q == S_FETCH) ? req_q.index : ptr_q;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    size_d  = size_q;
    ptr_d   = ptr_q;
    rv_d    = 1'b0;
    rd_d    = rd_q;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          req_d   = dec_fields;
          crc_clr = 1'b1;
          state_d = S_HDR;
        end
      end
      S_HDR: begin
        if (!st_hit) begin
          rv_d = 1'b1; rd_d = {6'd0, ERR_BAD_TYPE, KIND_ERR}; state_d = S_IDLE;
        end else if (hdr_size > SIZE_W'(req_q.limit)) begin
          rv_d = 1'b1; rd_d = {6'd0, ERR_TRUNC, KIND_ERR}; state_d = S_IDLE;
        end else if (req_q.want_crc) begin
          size_d  = hdr_size;
          ptr_d   = '0;
          state_d = S_CRC;
        end else if (SIZE_W'(req_q.index) >= hdr_size) begin
          rv_d = 1'b1; rd_d = {6'd0, ERR_BAD_INDEX, KIND_ERR}; state_d = S_IDLE;
        end else begin
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        rv_d    = 1'b1;
        rd_d    = {st_rdata, KIND_DATA};
        state_d = S_IDLE;
      end
      S_CRC: begin
        crc_en = 1'b1;
        ptr_d  = ptr_q + IDX_W'(1);
        if (SIZE_W'(ptr_q) == size_q - SIZE_W'(1)) begin
          rv_d    = 1'b1;
          rd_d    = {crc_val, KIND_CRC};
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      req_q   <= '0;
      size_q  <= '0;
      ptr_q   <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      size_q  <= size_d;
      ptr_q   <= ptr_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign rsp_valid    = rv_q;
  assign rsp_data     = rd_q;
  assign rsp_msg_type = rv_q ? MT_RESP : 8'h00;
endmodule

// File: rtl/blkrsp_checker.sv
module blkrsp_checker
  import blkrsp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [7:0]       req_msg_type,
  input logic             busy,
  input logic             rsp_valid,
  input logic [7:0]       rsp_msg_type,
  input logic [MSG_W-1:0] rsp_data
);
  logic is_known;
  assign is_known = (req_msg_type == MT_SMALL) || (req_msg_type == MT_MEDIUM) ||
                    (req_msg_type == MT_LARGE);

  // R2
  unknown_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !is_known) |=> (!busy && !rsp_valid));

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && is_known) |=> busy);

  // R11
  busy_excl_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);

  // R11
  busy_fall_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  rsp_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_msg_type == MT_RESP && rsp_data[1:0] != 2'd3));

  // R7
  err_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[1:0] == KIND_ERR) |-> (rsp_data[9:4] == 6'd0));
endmodule

bind blkrsp_top blkrsp_checker chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_msg_type (req_msg_type),
  .busy         (busy),
  .rsp_valid    (rsp_valid),
  .rsp_msg_type (rsp_msg_type),
  .rsp_data     (rsp_data)
);

// File: tb/blkrsp_top_test.sv
module blkrsp_top_test;
  logic       clk, rst_n, req_valid, busy, rsp_valid, st_hit;
  logic [7:0] req_msg_type, rsp_msg_type, st_rdata;
  logic [9:0] req_data, rsp_data;
  logic [4:0] st_type;
  logic [6:0] st_byte;

  int checks = 0;
  int errors = 0;
  logic       present [32];
  logic [7:0] lenb    [32];

  blkrsp_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msg_type(req_msg_type),
    .req_data(req_data), .busy(busy), .rsp_valid(rsp_valid), .rsp_msg_type(rsp_msg_type),
    .rsp_data(rsp_data), .st_type(st_type), .st_byte(st_byte), .st_hit(st_hit),
    .st_rdata(st_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] blk_byte(input int t, input int i);
    if (i == 0) return 8'(t + 8'h40);
    if (i == 1) return lenb[t];
    return 8'(t * 37 + i * 11 + 5);
  endfunction

  always_comb begin
    st_hit   = present[st_type];
    st_rdata = blk_byte(int'(st_type), int'(st_byte));
  end

  function automatic logic [7:0] crc_of(input int t, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c ^= blk_byte(t, i);
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h97) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [9:0] model(input logic [7:0] mt, input logic [9:0] d);
    int t, idx, lim, size;
    if (mt == 8'h09)      begin t = int'(d[3:0]);      idx = int'(d[8:4]); lim = 32;  end
    else if (mt == 8'h08) begin t = 16 + int'(d[2:0]); idx = int'(d[8:3]); lim = 64;  end
    else                  begin t = 24 + int'(d[1:0]); idx = int'(d[8:2]); lim = 128; end
    if (!present[t]) return {8'd0, 2'd2};
    size = int'(lenb[t]) + 2;
    if (size > lim) return {8'd2, 2'd2};
    if (d[9]) return {crc_of(t, size), 2'd1};
    if (idx >= size) return {8'd1, 2'd2};
    return {blk_byte(t, idx), 2'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_rsp(output logic got, output logic [9:0] data);
    got = 1'b0; data = '0;
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1; data = rsp_data;
        check("R6 type", {24'd0, rsp_msg_type}, 32'h03);
      end
    end
  endtask

  task automatic do_req(input string req, input logic [7:0] mt, input logic [9:0] d);
    logic got; logic [9:0] data;
    @(negedge clk);
    req_valid = 1'b1; req_msg_type = mt; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " busy"}, {31'd0, busy}, 32'd1);
    wait_rsp(got, data);
    check({req, " rsp"}, {21'd0, got, data}, {21'd0, 1'b1, model(mt, d)});
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got; logic [9:0] data;
    void'($urandom(32'd4711));
    for (int t = 0; t < 32; t++) begin present[t] = 1'b1; lenb[t] = 8'd10; end
    lenb[2] = 8'd30; lenb[1] = 8'd20; present[3] = 1'b0; lenb[5] = 8'd31;
    lenb[18] = 8'd62; lenb[27] = 8'd126; lenb[25] = 8'd200; present[17] = 1'b0;
    req_valid = 1'b0; req_msg_type = '0; req_data = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 rsp_type", {24'd0, rsp_msg_type}, 32'd0);
    rst_n = 1'b1;
    // R3 small decode, R6 data kind
    do_req("R3 small idx0", 8'h09, {1'b0, 5'd0, 4'd2});
    do_req("R3 small idx31", 8'h09, {1'b0, 5'd31, 4'd2});
    // R9 index boundary
    do_req("R9 idx size-1", 8'h09, {1'b0, 5'd21, 4'd1});
    do_req("R9 idx size", 8'h09, {1'b0, 5'd22, 4'd1});
    // R7 absent type, also with checksum
    do_req("R7 absent", 8'h09, {1'b0, 5'd25, 4'd3});
    do_req("R7 absent crc", 8'h08, {1'b1, 6'd0, 3'd1});
    // R8 truncated, precedes index and checksum
    do_req("R8 trunc small", 8'h09, {1'b0, 5'd3, 4'd5});
    do_req("R8 trunc large crc", 8'h07, {1'b1, 7'd127, 2'd1});
    // R4 medium decode
    do_req("R4 medium idx5", 8'h08, {1'b0, 6'd5, 3'd2});
    do_req("R4 medium idx63", 8'h08, {1'b0, 6'd63, 3'd2});
    // R5 large decode
    do_req("R5 large idx127", 8'h07, {1'b0, 7'd127, 2'd3});
    // R10 checksums
    do_req("R10 crc large", 8'h07, {1'b1, 7'd0, 2'd3});
    do_req("R10 crc small", 8'h09, {1'b1, 5'd9, 4'd2});
    // R2 unknown type ignored
    @(negedge clk);
    req_valid = 1'b1; req_msg_type = 8'h06; req_data = {1'b0, 5'd1, 4'd2};
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy", {31'd0, busy}, 32'd0);
    wait_rsp(got, data);
    check("R2 no rsp", {31'd0, got}, 32'd0);
    // R11 requests while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_msg_type = 8'h07; req_data = {1'b1, 7'd0, 2'd3};
    @(negedge clk);
    req_msg_type = 8'h09; req_data = {1'b0, 5'd4, 4'd2};
    check("R11 busy", {31'd0, busy}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(got, data);
    check("R11 first rsp", {21'd0, got, data}, {21'd0, 1'b1, model(8'h07, {1'b1, 7'd0, 2'd3})});
    check("R11 busy low", {31'd0, busy}, 32'd0);
    wait_rsp(got, data);
    check("R11 no second", {31'd0, got}, 32'd0);
    // random phase over randomised stores
    for (int r = 0; r < 4; r++) begin
      for (int t = 0; t < 32; t++) begin
        present[t] = ($urandom % 6) != 0;
        lenb[t] = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 127);
      end
      for (int n = 0; n < 80; n++) begin
        int sel = $urandom % 3;
        logic [7:0] mt = (sel == 0) ? 8'h07 : (sel == 1) ? 8'h08 : 8'h09;
        do_req("R10 R9 R8 R7 random", mt, 10'($urandom));
      end
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule